// File: doc/BRIEF.md
# Adjacent-Burst Correcting Parity Codec

This block protects a cache line in fixed 8-bit lanes. Each lane gets 8 check bits, so the code costs as much storage as the data it guards. Every check bit is the exclusive-OR of exactly two data bits that sit a cyclic distance apart. That distance, the shift, is 2 or 3 and is picked at run time by one select input that all lanes share. Because the code is this simple, the check bits take one gate level to build and the correction takes only a few.

The encoder side turns a line of data into its check bits. The decoder side takes a stored line and its check bits and returns three things: the repaired data, the per-bit syndrome, and one flag that says whether any lane saw a mismatch. The decoder can repair a single flipped bit. It can also repair two flipped neighbours, including the pair that wraps from bit 7 to bit 0. A lane that needs no protection is read with the bypass input set, and its data then passes through untouched. All outputs are registered once, so each result appears one clock after its inputs.

Top module: `aec_codec`

## Requirements
- R1: While rst_n is low, every output is zero. After reset, each output shows the result for the inputs sampled at the previous rising clock edge, which is one cycle of latency.
- R2: Lane L covers line bits L*8 to L*8+7, and bit b of that lane is line bit L*8+b. Check bit b of a lane is data bit b XOR data bit ((b - s) mod 8). The shift s is 2 when s_sel_i is 0 and 3 when s_sel_i is 1.
- R3: When bypass_i is 0, syndrome bit b of a lane is check bit b XOR data bit b XOR data bit ((b - s) mod 8).
- R4: If the check bits presented with the data are the correct ones, the syndrome is all zero, the error flag is 0 and the data comes out unchanged. This holds for both shift values.
- R5: If exactly one data bit of a lane is flipped, at any position, that lane's output data equals the original data. This holds for s = 2 and for s = 3.
- R6: If two neighbouring data bits b and (b+1) mod 8 of a lane are flipped, the lane's output data equals the original data. This includes the pair 7 and 0 and holds for both shift values.
- R7: If exactly one check bit of a lane is flipped, the lane's data comes out unchanged, exactly one syndrome bit of that lane is set, and the error flag is 1.
- R8: When bypass_i is 0, dec_err_o is the OR of every syndrome bit of every lane.
- R9: When bypass_i is 1, dec_data_o equals dec_data_i bit for bit, whatever the check bits are. In that case dec_syndrome_o is all zero and dec_err_o is 0.
- R10: Lanes are independent. A line with a different error pattern in each lane is repaired lane by lane under one shared shift select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| s_sel_i | input | 1 | Shift select for all lanes: 0 selects s = 2, 1 selects s = 3 |
| enc_data_i | input | LANES*8 | Line to encode |
| enc_parity_o | output | LANES*8 | Check bits of enc_data_i |
| dec_data_i | input | LANES*8 | Stored line to check and repair |
| dec_parity_i | input | LANES*8 | Stored check bits of dec_data_i |
| bypass_i | input | 1 | 1 passes dec_data_i through without correction |
| dec_data_o | output | LANES*8 | Repaired (or passed-through) line |
| dec_syndrome_o | output | LANES*8 | Per-bit syndrome, zero under bypass |
| dec_err_o | output | 1 | Any syndrome bit set, 0 under bypass |

## Verification
The assertions compare each registered output with the inputs of the previous cycle. They therefore assume that s_sel_i, bypass_i and the data buses are known, and that they stay stable around each rising edge. The stimulus changes every input only on the falling edge and never leaves an input undriven once reset ends. The corruption patterns are limited to the cases the code is specified to repair: no error, one data bit, one check bit, or two neighbouring data bits per lane. This keeps the expected data equal to the original line, except when bypass is set.

// File: rtl/aec_pkg.sv
package aec_pkg;

    localparam int unsigned LANE_W   = 8;
    localparam int unsigned SHIFT_LO = 2;
    localparam int unsigned SHIFT_HI = 3;

    typedef logic [LANE_W-1:0] lane_t;

    // cyclic index (pos + off) mod LANE_W, valid for |off| < LANE_W
    function automatic int unsigned wrap_idx(int pos, int off);
        return int'((pos + off + int'(LANE_W)) % int'(LANE_W));
    endfunction

endpackage

// File: rtl/aec_lane_enc.sv
module aec_lane_enc
    import aec_pkg::*;
(
    input  lane_t data_i,
    input  logic  s3_i,
    output lane_t parity_o
);

    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
        localparam int unsigned PART_LO = wrap_idx(b, -int'(SHIFT_LO));
        localparam int unsigned PART_HI = wrap_idx(b, -int'(SHIFT_HI));
        logic partner;
        assign partner     = s3_i ? data_i[PART_HI] : data_i[PART_LO];
        assign parity_o[b] = data_i[b] ^ partner;
    end

endmodule

// File: rtl/aec_lane_dec.sv
module aec_lane_dec
    import aec_pkg::*;
(
    input  lane_t data_i,
    input  lane_t parity_i,
    input  logic  s3_i,
    output lane_t data_o,
    output lane_t syndrome_o
);

    lane_t syn;

    // syndrome: stored check bit against a freshly built one
    for (genvar b = 0; b < LANE_W; b++) begin : g_syn
        localparam int unsigned PART_LO = wrap_idx(b, -int'(SHIFT_LO));
        localparam int unsigned PART_HI = wrap_idx(b, -int'(SHIFT_HI));
        logic partner;
        assign partner = s3_i ? data_i[PART_HI] : data_i[PART_LO];
        assign syn[b]  = parity_i[b] ^ data_i[b] ^ partner;
    end

    // a data bit flips when its own syndrome and the one s ahead both fire
    for (genvar b = 0; b < LANE_W; b++) begin : g_fix
        localparam int unsigned AHEAD_LO = wrap_idx(b, int'(SHIFT_LO));
        localparam int unsigned AHEAD_HI = wrap_idx(b, int'(SHIFT_HI));
        logic ahead;
        assign ahead     = s3_i ? syn[AHEAD_HI] : syn[AHEAD_LO];
        assign data_o[b] = data_i[b] ^ (syn[b] & ahead);
    end

    assign syndrome_o = syn;

endmodule

// File: rtl/aec_codec.sv
module aec_codec
    import aec_pkg::*;
#(
    parameter int unsigned LANES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s_sel_i,
    input  logic [LANES*LANE_W-1:0]   enc_data_i,
    output logic [LANES*LANE_W-1:0]   enc_parity_o,
    input  logic [LANES*LANE_W-1:0]   dec_data_i,
    input  logic [LANES*LANE_W-1:0]   dec_parity_i,
    input  logic                      bypass_i,
    output logic [LANES*LANE_W-1:0]   dec_data_o,
    output logic [LANES*LANE_W-1:0]   dec_syndrome_o,
    output logic                      dec_err_o
);

    localparam int unsigned LINE_W = LANES * LANE_W;

    typedef struct packed {
        logic [LINE_W-1:0] par;
        logic [LINE_W-1:0] data;
        logic [LINE_W-1:0] syn;
        logic              err;
    } out_t;

    out_t st_d, st_q;

    logic [LINE_W-1:0] enc_par_w;
    logic [LINE_W-1:0] fix_data_w;
    logic [LINE_W-1:0] syn_w;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        aec_lane_enc u_enc (
            .data_i   (enc_data_i[l*LANE_W +: LANE_W]),
            .s3_i     (s_sel_i),
            .parity_o (enc_par_w[l*LANE_W +: LANE_W])
        );
        aec_lane_dec u_dec (
            .data_i     (dec_data_i[l*LANE_W +: LANE_W]),
            .parity_i   (dec_parity_i[l*LANE_W +: LANE_W]),
            .s3_i       (s_sel_i),
            .data_o     (fix_data_w[l*LANE_W +: LANE_W]),
            .syndrome_o (syn_w[l*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.par = enc_par_w;
        if (bypass_i) begin
            st_d.data = dec_data_i;
            st_d.syn  = '0;
            st_d.err  = 1'b0;
        end else begin
            st_d.data = fix_data_w;
            st_d.syn  = syn_w;
            st_d.err  = |syn_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enc_parity_o   = st_q.par;
    assign dec_data_o     = st_q.data;
    assign dec_syndrome_o = st_q.syn;
    assign dec_err_o      = st_q.err;

    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_i)) |-> (dec_data_o == $past(dec_data_i))); // R9

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_i)) |-> (!dec_err_o && dec_syndrome_o == '0)); // R9

    AST_CLEAN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dec_syndrome_o == '0) |-> (dec_data_o == $past(dec_data_i))); // R4

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> (dec_syndrome_o != '0)); // R8

    AST_FIX_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (dec_data_o != $past(dec_data_i))) |-> dec_err_o); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (dec_data_o == '0 && !dec_err_o && enc_parity_o == '0)); // R1

endmodule

// File: tb/sim_aec_codec.sv
module sim_aec_codec;

    localparam int unsigned LANES = 64;
    localparam int unsigned W     = LANES * 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_sel_i = 1'b0;
    logic [W-1:0] enc_data_i = '0;
    logic [W-1:0] enc_parity_o;
    logic [W-1:0] dec_data_i = '0;
    logic [W-1:0] dec_parity_i = '0;
    logic         bypass_i = 1'b0;
    logic [W-1:0] dec_data_o;
    logic [W-1:0] dec_syndrome_o;
    logic         dec_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    aec_codec #(.LANES(LANES)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .s_sel_i        (s_sel_i),
        .enc_data_i     (enc_data_i),
        .enc_parity_o   (enc_parity_o),
        .dec_data_i     (dec_data_i),
        .dec_parity_i   (dec_parity_i),
        .bypass_i       (bypass_i),
        .dec_data_o     (dec_data_o),
        .dec_syndrome_o (dec_syndrome_o),
        .dec_err_o      (dec_err_o)
    );

    function automatic logic [W-1:0] ref_par(logic [W-1:0] d, logic s3);
        logic [W-1:0] r;
        int sh;
        sh = s3 ? 3 : 2;
        for (int l = 0; l < LANES; l++)
            for (int b = 0; b < 8; b++)
                r[l*8+b] = d[l*8+b] ^ d[l*8 + ((b + 8 - sh) % 8)];
        return r;
    endfunction

    function automatic logic [W-1:0] ref_syn(logic [W-1:0] d, logic [W-1:0] p, logic s3);
        return p ^ ref_par(d, s3);
    endfunction

    function automatic logic [W-1:0] rand_line();
        logic [W-1:0] r;
        for (int i = 0; i < W/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic check_vec(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive on the falling edge, sample 1 ns after the next rising edge
    task automatic run_case(string req, logic [W-1:0] d, logic [W-1:0] derr,
                            logic [W-1:0] perr, logic s3, logic byp);
        logic [W-1:0] din, pin, esyn, edata;
        @(negedge clk);
        din          = d ^ derr;
        pin          = ref_par(d, s3) ^ perr;
        enc_data_i   = d;
        dec_data_i   = din;
        dec_parity_i = pin;
        s_sel_i      = s3;
        bypass_i     = byp;
        @(posedge clk);
        #1;
        esyn  = byp ? '0 : ref_syn(din, pin, s3);
        edata = byp ? din : d;
        check_vec({req, " R2 parity"}, enc_parity_o, ref_par(d, s3));
        check_vec({req, " R3 syndrome"}, dec_syndrome_o, esyn);
        check_bit({req, " R8 flag"}, dec_err_o, |esyn);
        check_vec({req, " data"}, dec_data_o, edata);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d, derr, perr;
        void'($urandom(32'd5171));

        // R1: reset clears outputs despite active inputs
        enc_data_i   = {W/8{8'hA5}};
        dec_data_i   = {W/8{8'h3C}};
        dec_parity_i = {W/8{8'hFF}};
        repeat (3) @(posedge clk);
        #1;
        check_vec("R1 reset parity", enc_parity_o, '0);
        check_vec("R1 reset data", dec_data_o, '0);
        check_vec("R1 reset syndrome", dec_syndrome_o, '0);
        check_bit("R1 reset flag", dec_err_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: clean lines, both shifts
        for (int s = 0; s < 2; s++) begin
            d = rand_line();
            run_case("R4 clean", d, '0, '0, s[0], 1'b0);
            check_bit("R4 clean flag low", dec_err_o, 1'b0);
        end

        // R5: single data bit at every lane position, both shifts
        for (int s = 0; s < 2; s++)
            for (int b = 0; b < 8; b++) begin
                d = rand_line();
                derr = '0;
                derr[b] = 1'b1;
                derr[8*9 + ((b + 3) % 8)] = 1'b1;
                run_case("R5 single data", d, derr, '0, s[0], 1'b0);
            end

        // R6: neighbour pairs including the 7/0 wrap, both shifts
        for (int s = 0; s < 2; s++)
            for (int b = 0; b < 8; b++) begin
                d = rand_line();
                derr = '0;
                derr[8*5 + b] = 1'b1;
                derr[8*5 + ((b + 1) % 8)] = 1'b1;
                run_case("R6 adjacent pair", d, derr, '0, s[0], 1'b0);
            end

        // R7: single check bit
        for (int s = 0; s < 2; s++)
            for (int b = 0; b < 8; b++) begin
                d = rand_line();
                perr = '0;
                perr[8*2 + b] = 1'b1;
                run_case("R7 single check bit", d, '0, perr, s[0], 1'b0);
                checks++;
                if ($countones(dec_syndrome_o) != 1) begin
                    errors++;
                    $display("FAIL R7 syndrome weight actual=%0d expected=1",
                             $countones(dec_syndrome_o));
                end
            end

        // R9: bypass with heavy corruption
        d    = rand_line();
        derr = rand_line();
        perr = rand_line();
        run_case("R9 bypass", d, derr, perr, 1'b1, 1'b1);
        run_case("R9 bypass s2", d, derr, perr, 1'b0, 1'b1);

        // R10: random per-lane patterns under one shared shift
        for (int it = 0; it < 300; it++) begin
            logic s3, byp;
            d    = rand_line();
            derr = '0;
            perr = '0;
            s3   = $urandom_range(0, 1);
            byp  = ($urandom_range(0, 7) == 0);
            for (int l = 0; l < LANES; l++) begin
                int kind, pos;
                kind = $urandom_range(0, 3);
                pos  = $urandom_range(0, 7);
                case (kind)
                    1: derr[l*8 + pos] = 1'b1;
                    2: begin
                        derr[l*8 + pos] = 1'b1;
                        derr[l*8 + ((pos + 1) % 8)] = 1'b1;
                    end
                    3: perr[l*8 + pos] = 1'b1;
                    default: ;
                endcase
            end
            run_case("R10 random lanes", d, derr, perr, s3, byp);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule